// File: doc/BRIEF.md
# Byte-Lane Load/Store Memory Interface

This block sits in the memory stage of a five-stage pipeline, between the pipeline and a data RAM that is organised in 32-bit words. It accepts word and byte loads and stores with a 32-bit byte address. For each access it produces a word address, a four-bit byte-write mask and lane-aligned write data. When a load's data returns from the RAM one cycle later, the block aligns it, sign-extends it where needed, and passes it on to writeback.

Only the lowest 1 MiB of the byte address space is backed by RAM. The block decodes this range itself. An access above it never enables the RAM: it does not fold back onto low memory. Stores there are dropped, and loads there return zero. The byte order is little endian: byte lane k holds bits 8k+7 down to 8k of a word. Word accesses are taken to be aligned, and misalignment is not detected.

Top module: `mem_lane_if`

## Requirements
- R1: While reset is held and on the first cycle after it, `ld_valid` is low. With no request presented, `mem_we` is 0000.
- R2: For an access whose address is below 0x00100000, `mem_en` is high and `mem_word_addr` equals byte address bits [19:2], in the same cycle as the request.
- R3: A backed word store drives `mem_we` = 1111 and `mem_wdata` equal to the store data.
- R4: A backed byte store drives exactly one `mem_we` bit, bit number addr[1:0]. The store byte appears on that lane of `mem_wdata`, that is, on bits 8*addr[1:0]+7 down to 8*addr[1:0].
- R5: A store to any address at or above 0x00100000 drives `mem_we` = 0000, so RAM contents are unchanged.
- R6: No access at or above 0x00100000 raises `mem_en`, so such an address never aliases into low RAM.
- R7: A backed word load gives `ld_valid` high in the cycle after the request, with `ld_data` equal to the full RAM word.
- R8: A backed byte load returns byte lane addr[1:0] of the RAM word, sign-extended from its bit 7 to 32 bits.
- R9: A load from an unbacked address returns `ld_data` = 0 with `ld_valid` high in the cycle after the request.
- R10: `ld_valid` is high in a cycle exactly when a load was accepted in the previous cycle. It is never high after a store or after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (byte stores use bits [7:0]) |
| mem_en | output | 1 | RAM access enable |
| mem_word_addr | output | 18 | RAM word address |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | RAM read word, one cycle after `mem_en` |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Aligned, extended load result |

## Verification
The assertions check the following on every cycle:
- that no enable or write mask leaves the block for an unbacked address;
- that a byte store raises exactly the one lane selected by the address;
- that a word store writes all four lanes with unchanged data;
- that `ld_valid` follows accepted loads by exactly one cycle;
- that byte results carry a clean sign extension and unbacked loads read zero.

Only the bench scenarios can show what the stores actually leave behind, which takes a write followed by a later read:
- a byte store merging into an existing word;
- each lane read back with the right sign;
- the top word of the backed range;
- a store just past the 1 MiB boundary leaving the low word untouched.

// File: rtl/mem_lane_if.sv
module mem_lane_if #(
  parameter int ADDR_W      = 32,
  parameter int BACKED_LOG2 = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic                  req_byte,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  mem_en,
  output logic [BACKED_LOG2-3:0] mem_word_addr,
  output logic [3:0]            mem_we,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  output logic                  ld_valid,
  output logic [31:0]           ld_data
);
  localparam int LANES = 4;

  logic             in_range;
  logic [1:0]       lane;
  logic [LANES-1:0] lane_mask;
  logic             is_load;

  logic       pend_q;
  logic       byte_q;
  logic       hit_q;
  logic [1:0] lane_q;
  logic [7:0] picked;

  assign in_range  = ~|req_addr[ADDR_W-1:BACKED_LOG2];
  assign lane      = req_addr[1:0];
  assign lane_mask = LANES'(1) << lane;
  assign is_load   = req_valid & ~req_store;

  assign mem_en        = req_valid & in_range;
  assign mem_word_addr = req_addr[BACKED_LOG2-1:2];
  assign mem_we        = (mem_en & req_store) ? (req_byte ? lane_mask : {LANES{1'b1}}) : '0;
  assign mem_wdata     = req_byte ? {LANES{req_wdata[7:0]}} : req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= 1'b0;
      hit_q  <= 1'b0;
      lane_q <= 2'd0;
    end else begin
      pend_q <= is_load;
      if (is_load) begin
        byte_q <= req_byte;
        hit_q  <= in_range;
        lane_q <= lane;
      end
    end
  end

  assign picked   = mem_rdata[lane_q*8 +: 8];
  assign ld_valid = pend_q;
  assign ld_data  = !hit_q ? 32'h0 :
                    byte_q ? {{24{picked[7]}}, picked} : mem_rdata;
endmodule

module mem_lane_if_chk #(
  parameter int ADDR_W      = 32,
  parameter int BACKED_LOG2 = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic              req_byte,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              mem_en,
  input logic [3:0]        mem_we,
  input logic [31:0]       mem_wdata,
  input logic              ld_valid,
  input logic [31:0]       ld_data
);
  logic high_addr;
  assign high_addr = |req_addr[ADDR_W-1:BACKED_LOG2];

  assert_unbacked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && high_addr) |-> (!mem_en && mem_we == 4'h0));

  assert_sb_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_byte && !high_addr) |->
      ($countones(mem_we) == 1 && mem_we[req_addr[1:0]]
       && mem_wdata[req_addr[1:0]*8 +: 8] == req_wdata[7:0]));

  assert_sw_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_byte && !high_addr) |->
      (mem_we == 4'hF && mem_wdata == req_wdata));

  assert_ld_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> ld_valid);

  assert_no_spurious_ld_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_store) |=> !ld_valid);

  assert_unbacked_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && high_addr) |=> (ld_data == 32'h0));

  assert_lb_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && req_byte) |=> (ld_data[31:8] == {24{ld_data[7]}}));
endmodule

bind mem_lane_if mem_lane_if_chk #(.ADDR_W(ADDR_W), .BACKED_LOG2(BACKED_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
  .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/mem_lane_if_tb.sv
`timescale 1ns/1ps
module mem_lane_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic        req_byte = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_en;
  logic [17:0] mem_word_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  always #4 clk = ~clk;

  mem_lane_if dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_word_addr(mem_word_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  logic [31:0] ram [int unsigned];
  always @(posedge clk) begin
    if (mem_en) begin
      logic [31:0] w;
      w = ram.exists(mem_word_addr) ? ram[mem_word_addr] : 32'h0;
      mem_rdata <= w;
      for (int k = 0; k < 4; k++)
        if (mem_we[k]) w[k*8 +: 8] = mem_wdata[k*8 +: 8];
      ram[mem_word_addr] = w;
    end
  end

  logic [7:0]  ref_mem [int unsigned];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic op(input bit st, input bit by, input logic [31:0] a, input logic [31:0] d);
    bit backed;
    logic [31:0] e;
    backed = (a < 32'h0010_0000);
    req_valid = 1; req_store = st; req_byte = by; req_addr = a; req_wdata = d;
    #1;
    if (backed) begin
      check(mem_en == 1'b1, "R2", {31'b0, mem_en}, 32'h1);
      check(mem_word_addr == a[19:2], "R2", {14'b0, mem_word_addr}, {14'b0, a[19:2]});
    end else begin
      check(mem_en == 1'b0, "R6", {31'b0, mem_en}, 32'h0);
    end
    if (st) begin
      if (!backed) check(mem_we == 4'h0, "R5", {28'b0, mem_we}, 32'h0);
      else if (by) begin
        check(mem_we == (4'b1 << a[1:0]), "R4", {28'b0, mem_we}, {28'b0, 4'b1 << a[1:0]});
        check(mem_wdata[a[1:0]*8 +: 8] == d[7:0], "R4", {24'b0, mem_wdata[a[1:0]*8 +: 8]}, {24'b0, d[7:0]});
        ref_mem[a] = d[7:0];
      end else begin
        check(mem_we == 4'hF, "R3", {28'b0, mem_we}, 32'hF);
        check(mem_wdata == d, "R3", mem_wdata, d);
        for (int k = 0; k < 4; k++) ref_mem[{a[31:2], 2'b00} + k] = d[k*8 +: 8];
      end
    end else begin
      if (!backed) begin e = 32'h0; tag_q.push_back("R9"); end
      else if (by) begin
        e = {{24{ref_byte(a)[7]}}, ref_byte(a)}; tag_q.push_back("R8");
      end else begin
        for (int k = 0; k < 4; k++) e[k*8 +: 8] = ref_byte({a[31:2], 2'b00} + k);
        tag_q.push_back("R7");
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 0; req_store = 0; req_byte = 0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (ld_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10", 32'h1, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(ld_data == e, t, ld_data, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = 32'h10;
    @(negedge clk);
    check(ld_valid == 1'b0, "R1", {31'b0, ld_valid}, 32'h0);
    req_valid = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    check(ld_valid == 1'b0, "R1", {31'b0, ld_valid}, 32'h0);
    check(mem_we == 4'h0, "R1", {28'b0, mem_we}, 32'h0);
    @(negedge clk);

    op(1, 0, 32'h0000_0010, 32'h1122_3344);
    op(0, 0, 32'h0000_0010, 0);
    op(1, 1, 32'h0000_0011, 32'h0000_00AA);
    op(0, 0, 32'h0000_0010, 0);
    for (int k = 0; k < 4; k++) op(0, 1, 32'h10 + k, 0);
    op(1, 0, 32'h0000_0020, 32'h807F_0180);
    for (int k = 0; k < 4; k++) op(0, 1, 32'h20 + k, 0);
    op(1, 1, 32'h0000_0023, 32'hFFFF_FF7F);
    op(0, 0, 32'h0000_0020, 0);
    op(1, 0, 32'h000F_FFFC, 32'hCAFE_F00D);
    op(0, 0, 32'h000F_FFFC, 0);
    op(0, 1, 32'h000F_FFFF, 0);
    op(1, 0, 32'h0010_0010, 32'hDEAD_BEEF);
    op(1, 1, 32'h0010_0011, 32'h0000_0055);
    op(1, 1, 32'hFFFF_FFFF, 32'h0000_0066);
    op(0, 0, 32'h0000_0010, 0);
    op(0, 0, 32'h0010_0010, 0);
    op(0, 1, 32'h8000_0003, 0);
    op(0, 0, 32'h0000_0000, 0);
    @(negedge clk);
    check(ld_valid == 1'b0, "R10", {31'b0, ld_valid}, 32'h0);
    @(negedge clk);
    check(exp_q.size() == 0, "R10", exp_q.size(), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule